// File: doc/BRIEF.md
# Single-Level Page Table Translation Unit

This block turns a 32-bit virtual address into a physical address. It does so by walking a one-level page table that sits in a word-organized memory. A table base address, supplied with each request, locates the table. The virtual page number selects one 4-byte entry in it. Because the table holds an entry for every virtual page, no tag compare is needed. The unit fetches the entry and checks its valid flag. If the flag is clear, it reports a page fault. If the flag is set, it joins the physical page number to the untouched page offset.

Alongside the translation, the unit keeps the entry's usage history up to date in hardware. Every access marks the page as referenced, and a write access also marks it as modified. The updated entry is written back to the same table location, but only when one of these flags actually changes value. Only one translation is in flight at a time. A request is taken only while the unit is idle, and the result comes back as a one-cycle response that carries the address and a fault flag.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_rd_en and mem_wr_en are all 0.
- R2: For each accepted request, exactly one read is issued, at byte address tbl_base + (vaddr[31:12] * 4), using the base sampled when the request is accepted.
- R3: When entry bit 31 (valid) is set, the response has rsp_fault = 0 and rsp_paddr = {entry[19:0], vaddr[11:0]}.
- R4: When entry bit 31 is clear, the response has rsp_fault = 1 and rsp_paddr = 0, and no memory write takes place.
- R5: When a valid entry has bit 30 (referenced) clear, the entry is written back to the same address with bit 30 set, and all other bits are kept except as R6 allows.
- R6: A write access (req_write = 1) to a valid entry with bit 29 (modified) clear writes the entry back with both bit 29 and bit 30 set.
- R7: No write-back occurs when the flags would not change: a read with bit 30 already set, or a write with bits 30 and 29 both set.
- R8: A read access never sets bit 29, and it never clears a bit 29 that is already set.
- R9: From acceptance until the response, req_ready is 0. A request presented during that time is ignored and causes no memory access.
- R10: rsp_valid is a single-cycle pulse per accepted request. It appears only after any write-back has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request is accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store (1) or a load (0) |
| tbl_base | input | 32 | Byte address of the page table, sampled at acceptance |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page not present |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_wr_en | output | 1 | Entry write-back strobe |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench targets the flag update cases one by one: a first read, a first write, a write to a page already referenced, and accesses whose flags are already set. A design that always wrote back would show a spurious store there, and one that lost bits during the update would show corrupted unused bits or a wrong page number in the store. Invalid entries are read and written to make sure that a fault never writes memory and returns a zero address. Reads of already-modified pages catch a design that clears the modified bit. A second request held during a walk, and a non-default table base, expose a unit that accepts while busy or forms the entry address wrongly.

// File: rtl/vx_pkg.sv
// Shared constants and types for the page table translation unit.
// Assumes a 32-bit address space, 4 KB pages and 4-byte table entries.
package vx_pkg;
    parameter int VA_W   = 32;              // virtual and physical address width
    parameter int OFF_W  = 12;              // page offset width (4 KB pages)
    parameter int PTE_W  = 32;              // table entry width
    parameter int PPN_W  = 20;              // physical page number width in entry
    parameter int V_BIT  = 31;              // entry present flag
    parameter int R_BIT  = 30;              // entry referenced flag
    parameter int D_BIT  = 29;              // entry modified flag
    localparam int VPN_W  = VA_W - OFF_W;   // virtual page number width
    localparam int ENT_SH = $clog2(PTE_W / 8); // byte shift per entry

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_WB,
        S_RESP
    } walk_state_t;
endpackage

// File: rtl/vx_pte_addr.sv
// Entry address generator: forms the byte address of a table entry from the
// table base and the virtual page number. Purely combinational.
module vx_pte_addr
    import vx_pkg::*;
(
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] ent_addr
);
    logic [VPN_W-1:0] vpn;

    // Scale the page number by the entry size and add the base.
    always_comb begin
        vpn      = vaddr[VA_W-1:OFF_W];
        ent_addr = base + (VA_W'(vpn) << ENT_SH);
    end
endmodule

// File: rtl/vx_pte_eval.sv
// Entry evaluator: decides fault, builds the flag-updated entry and flags
// whether a write-back is needed. Purely combinational.
module vx_pte_eval
    import vx_pkg::*;
(
    input  logic [PTE_W-1:0] ent,
    input  logic             is_wr,
    output logic             miss,
    output logic             upd,
    output logic [PTE_W-1:0] ent_new,
    output logic [PPN_W-1:0] ppn
);
    // Set referenced always, modified on stores; write back only on change.
    always_comb begin
        ent_new        = ent;
        ent_new[R_BIT] = 1'b1;
        if (is_wr) begin
            ent_new[D_BIT] = 1'b1;
        end
        miss = !ent[V_BIT];
        upd  = !miss && (ent_new != ent);
        ppn  = ent[PPN_W-1:0];
    end
endmodule

// File: rtl/vpage_xlate.sv
// Single-level page table walker. Accepts one translation at a time, reads
// the entry, returns the physical address or a fault, and writes the entry
// back when its referenced/modified flags change. Assumes the memory returns
// exactly one mem_rvalid per mem_rd_en, at any latency of one cycle or more.
module vpage_xlate
    import vx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [VA_W-1:0]  tbl_base,
    output logic             rsp_valid,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [VA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    walk_state_t      state;
    logic [VA_W-1:0]  va_q;
    logic [VA_W-1:0]  base_q;
    logic             wr_q;
    logic [PTE_W-1:0] ent_new_q;
    logic [VA_W-1:0]  paddr_q;
    logic             fault_q;

    logic [VA_W-1:0]  ent_addr;
    logic             ev_miss;
    logic             ev_upd;
    logic [PTE_W-1:0] ev_new;
    logic [PPN_W-1:0] ev_ppn;

    vx_pte_addr u_addr (
        .base     (base_q),
        .vaddr    (va_q),
        .ent_addr (ent_addr)
    );

    vx_pte_eval u_eval (
        .ent     (mem_rdata),
        .is_wr   (wr_q),
        .miss    (ev_miss),
        .upd     (ev_upd),
        .ent_new (ev_new),
        .ppn     (ev_ppn)
    );

    // Walk sequencer: accept, read, evaluate, optional write-back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            va_q      <= '0;
            base_q    <= '0;
            wr_q      <= 1'b0;
            ent_new_q <= '0;
            paddr_q   <= '0;
            fault_q   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        base_q <= tbl_base;
                        wr_q   <= req_write;
                        state  <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (mem_rvalid) begin
                        ent_new_q <= ev_new;
                        fault_q   <= ev_miss;
                        paddr_q   <= ev_miss ? '0 : {ev_ppn, va_q[OFF_W-1:0]};
                        state     <= ev_upd ? S_WB : S_RESP;
                    end
                end
                S_WB:    state <= S_RESP;
                S_RESP:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Port drive derived from the sequencer state.
    always_comb begin
        req_ready = (state == S_IDLE);
        mem_rd_en = (state == S_ISSUE);
        mem_wr_en = (state == S_WB);
        rsp_valid = (state == S_RESP);
        mem_addr  = ent_addr;
        mem_wdata = ent_new_q;
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
    end
endmodule

// File: rtl/vx_xlate_chk.sv
// Protocol and update checker for vpage_xlate, attached by bind. It keeps
// its own copy of the accepted request and of the entry read.
module vx_xlate_chk
    import vx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_write,
    input logic [VA_W-1:0]  tbl_base,
    input logic             rsp_valid,
    input logic [VA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic [VA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata,
    input logic             mem_rvalid,
    input logic [PTE_W-1:0] mem_rdata
);
    logic [VA_W-1:0]  c_va;
    logic [VA_W-1:0]  c_base;
    logic             c_wr;
    logic [PTE_W-1:0] c_ent;
    logic             c_wrote;

    // Shadow the accepted request, the returned entry and write activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_va    <= '0;
            c_base  <= '0;
            c_wr    <= 1'b0;
            c_ent   <= '0;
            c_wrote <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                c_va    <= req_vaddr;
                c_base  <= tbl_base;
                c_wr    <= req_write;
                c_wrote <= 1'b0;
            end else if (mem_wr_en) begin
                c_wrote <= 1'b1;
            end
            if (mem_rvalid) begin
                c_ent <= mem_rdata;
            end
        end
    end

    p_rd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_addr == c_base + {c_va[VA_W-1:OFF_W], 2'b00});

    p_hit_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |->
            (rsp_paddr == {c_ent[PPN_W-1:0], c_va[OFF_W-1:0]}));

    p_fault_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!c_wrote && rsp_paddr == '0));

    p_wb_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wdata[R_BIT] && mem_wdata[V_BIT] &&
                       mem_wdata[PPN_W-1:0] == c_ent[PPN_W-1:0]));

    p_wb_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (!c_ent[R_BIT] || (c_wr && !c_ent[D_BIT])));

    p_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wdata[D_BIT] == (c_ent[D_BIT] || c_wr)));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en) && !(rsp_valid && mem_wr_en));
endmodule

bind vpage_xlate vx_xlate_chk u_chk (.*);

// File: tb/vpage_xlate_tb.sv
module vpage_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    localparam logic [31:0] BASE = 32'h0000_0100;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [31:0] ent;
        logic [31:0] exp_pa;
        logic        exp_flt;
        logic        exp_wb;
        logic [31:0] exp_wd;
    } vec_t;

    // Entry: bit31 valid, bit30 referenced, bit29 modified, [19:0] page.
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1ABC, 1'b0, 32'h8000_0055, 32'h0005_5ABC, 1'b0, 1'b1, 32'hC000_0055},
        '{32'h0000_2004, 1'b1, 32'h8000_0ABC, 32'h00AB_C004, 1'b0, 1'b1, 32'hE000_0ABC},
        '{32'h0000_3FFF, 1'b0, 32'hC000_1234, 32'h0123_4FFF, 1'b0, 1'b0, 32'h0},
        '{32'h0000_4000, 1'b1, 32'hE00F_FFFF, 32'hFFFF_F000, 1'b0, 1'b0, 32'h0},
        '{32'h0000_5123, 1'b0, 32'hE000_0777, 32'h0077_7123, 1'b0, 1'b0, 32'h0},
        '{32'h0000_6010, 1'b0, 32'h0000_0042, 32'h0000_0000, 1'b1, 1'b0, 32'h0},
        '{32'h0000_7020, 1'b1, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 32'h0},
        '{32'h0000_8ABC, 1'b1, 32'hC1F0_0321, 32'h0032_1ABC, 1'b0, 1'b1, 32'hE1F0_0321},
        '{32'h0000_9000, 1'b0, 32'h9550_0007, 32'h0000_7000, 1'b0, 1'b1, 32'hD550_0007}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] tbl_base = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    logic [31:0] mem [256];
    logic        pre_en = 1'b0;
    logic [7:0]  pre_idx = '0;
    logic [31:0] pre_dat = '0;
    logic        cnt_clr = 1'b0;
    int          rd_cnt, wr_cnt;
    logic [31:0] rd_addr, wr_addr, wr_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] got_pa;
    logic        got_flt, got_rsp;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpage_xlate u_dut (.*);

    // Table memory model: one-cycle read latency, logs every access.
    always @(posedge clk) begin
        if (!rst_n) mem_rvalid <= 1'b0;
        else        mem_rvalid <= mem_rd_en;
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[9:2]];
            rd_cnt    <= rd_cnt + 1;
            rd_addr   <= mem_addr;
        end
        if (mem_wr_en) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= mem_addr;
            wr_data <= mem_wdata;
        end
        if (pre_en) mem[pre_idx] <= pre_dat;
        if (cnt_clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] idx, input logic [31:0] dat);
        @(negedge clk);
        pre_en = 1'b1; pre_idx = idx; pre_dat = dat; cnt_clr = 1'b1;
        @(negedge clk);
        pre_en = 1'b0; cnt_clr = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input logic wr, input logic [31:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; tbl_base = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
        got_rsp = rsp_valid; got_pa = rsp_paddr; got_flt = rsp_fault;
        @(negedge clk);
        chk(!rsp_valid, "R10 pulse", {31'b0, rsp_valid}, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
        chk({rsp_valid, mem_rd_en, mem_wr_en} == 3'b000, "R1 idle outputs",
            {29'b0, rsp_valid, mem_rd_en, mem_wr_en}, 32'h0);
        rst_n = 1'b1;

        // Vector table walk: R2..R8 and R10 ordering
        for (int v = 0; v < NV; v++) begin
            preload(8'(64 + VECS[v].va[19:12]), VECS[v].ent);
            xlate(VECS[v].va, VECS[v].wr, BASE);
            chk(got_rsp, "R10 response seen", {31'b0, got_rsp}, 32'h1);
            chk(rd_cnt == 1 && rd_addr == BASE + {VECS[v].va[31:12], 2'b00},
                "R2 entry read", rd_addr, BASE + {VECS[v].va[31:12], 2'b00});
            chk(got_flt == VECS[v].exp_flt, "R3/R4 fault flag",
                {31'b0, got_flt}, {31'b0, VECS[v].exp_flt});
            chk(got_pa == VECS[v].exp_pa, "R3/R4 physical address", got_pa,
                VECS[v].exp_pa);
            chk(wr_cnt == int'(VECS[v].exp_wb), "R5/R7 write-back count",
                32'(wr_cnt), {31'b0, VECS[v].exp_wb});
            if (VECS[v].exp_wb) begin
                chk(wr_data == VECS[v].exp_wd && wr_addr == rd_addr,
                    "R5/R6/R8 written entry", wr_data, VECS[v].exp_wd);
            end
        end

        // R2: a different table base moves the entry address
        preload(8'd131, 32'hC000_0999);
        xlate(32'h0000_3456, 1'b0, 32'h0000_0200);
        chk(rd_addr == 32'h0000_020C, "R2 alternate base", rd_addr, 32'h0000_020C);
        chk(got_pa == 32'h0099_9456, "R3 alternate base", got_pa, 32'h0099_9456);

        // R9: request held during a walk is ignored
        preload(8'd74, 32'hC000_0010);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_A123; req_write = 1'b0; tbl_base = BASE;
        @(negedge clk);
        req_vaddr = 32'h0000_B000; req_write = 1'b1;
        chk(!req_ready, "R9 busy ready low", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
        chk(!req_ready, "R9 busy ready low 2", {31'b0, req_ready}, 32'h0);
        req_valid = 1'b0;
        for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
        chk(rsp_paddr == 32'h0001_0123, "R9 first request served", rsp_paddr,
            32'h0001_0123);
        repeat (6) @(negedge clk);
        chk(rd_cnt == 1 && wr_cnt == 0, "R9 no extra access", 32'(rd_cnt), 32'h1);
        chk(req_ready, "R9 ready after response", {31'b0, req_ready}, 32'h1);

        // R6 then R7: second write to the same page needs no write-back
        preload(8'd75, 32'h8000_0222);
        xlate(32'h0000_B010, 1'b1, BASE);
        chk(wr_cnt == 1 && wr_data == 32'hE000_0222, "R6 first store", wr_data,
            32'hE000_0222);
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        xlate(32'h0000_B020, 1'b1, BASE);
        chk(wr_cnt == 0, "R7 repeated store", 32'(wr_cnt), 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule